// File: doc/BRIEF.md
# Fractional-Ratio Memory Clock Divider

This block derives a memory clock from a faster core clock. A 3-bit ratio code selects a divide ratio from 2 to 5 in steps of one half. The clock is generated with flops on both core-clock edges, combined through an XOR pair. The result is that every output period is a whole number of core half-cycles, and the output stays free of glitches.

The ratio code and a start control bit come straight from register fields. The divider holds its output low after reset until software arms it. Software arms it by driving the start bit from 0 to 1. That same rising transition is the only way a new ratio is taken in. A ratio taken in while the clock runs waits for the end of the current pair of output periods, so no period is ever cut short. A core-domain strobe marks the core cycle in which each rising edge of the output occurs. Logic in the core domain can use this strobe to act in step with the memory clock.

Top module: `mcd_frac_clkdiv`

## Requirements
- R1: An applied ratio code c (1 to 7) gives an output period of exactly c+3 core half-cycles: 001 gives ÷2, 010 gives ÷2.5, and so on in half steps up to 111 giving ÷5.
- R2: A code of 000 present at an arming transition is never applied. The previously applied ratio stays in force, and an arming while stopped still starts the clock with that ratio.
- R3: After reset, the applied ratio is code 011 (÷3).
- R4: A change of the ratio code has no effect on the output unless it is followed by a 0-to-1 transition of the start bit, sampled on the core rising edge.
- R5: Holding the start bit at 1 does not re-arm. A code written while start stays high is ignored until start falls and rises again.
- R6: After reset the output is low. It stays low until the first arming transition. When the start rise is sampled at core edge k, the output rises at core edge k+1.
- R7: While running, an armed ratio replaces the old one only at the end of a pair of output periods. Until then the old pattern continues, and the later of two armings made within one pair is the one applied.
- R8: Each output period of P half-cycles starts with a rising edge. The output is high for ceil(P/2) half-cycles and low for the rest, so for odd P the edges alternate between core rising and falling edges.
- R9: `mem_clk_rise` is high for exactly the one core cycle, from rising edge to rising edge, in which the output makes a rising edge, and is low at all other times.
- R10: Once started, the output keeps running when the start bit returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Core clock, both edges used |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_bit | input | 1 | Start/arm control; a 0-to-1 transition arms |
| ratio_code | input | 3 | Requested ratio code (CODE_W bits) |
| mem_clk | output | 1 | Divided memory clock |
| mem_clk_rise | output | 1 | Core-domain strobe for the cycle holding a rising edge of mem_clk |

## Verification
The hardest situation to reach from the ports is an arming that lands in the last core cycle of an output pair, or a second arming made before a first one has been applied. Only there do the boundary load and the overwrite of the pending ratio interact. To get there, the stimulus mixes directed sweeps of every code with several thousand cycles of random start toggling and random codes, 000 included. Many armings therefore fall on pair ends and into the same pair. Both halves of every core cycle are compared with a reference waveform built from the requirements.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

   // Half-cycle length of one output period for an applied code.
   function automatic int period_half(input int code, input int min_half);
      return code + min_half - 1;
   endfunction

   // Largest period in half-cycles for a code width.
   function automatic int period_half_max(input int code_w, input int min_half);
      return (1 << code_w) + min_half - 2;
   endfunction

endpackage

// File: rtl/mcd_ratio_ctl.sv
module mcd_ratio_ctl #(
   parameter int CODE_W       = 3,
   parameter int DEFAULT_CODE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              wrap_i,
   output logic              run_o,
   output logic [CODE_W-1:0] code_o
);

   localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(DEFAULT_CODE);

   logic              start_q;
   logic              running;
   logic              pend_v;
   logic [CODE_W-1:0] pend_code;
   logic [CODE_W-1:0] cur_code;
   logic              arm;
   logic              code_nz;

   assign arm     = start_i & ~start_q;
   assign code_nz = |code_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q   <= 1'b0;
         running   <= 1'b0;
         pend_v    <= 1'b0;
         pend_code <= RST_CODE;
         cur_code  <= RST_CODE;
      end else begin
         start_q <= start_i;
         if (!running) begin
            pend_v <= 1'b0;
            if (arm) begin
               running <= 1'b1;
               if (code_nz) cur_code <= code_i;
            end
         end else begin
            if (wrap_i && pend_v) cur_code <= pend_code;
            if (arm && code_nz) begin
               pend_code <= code_i;
               pend_v    <= 1'b1;
            end else if (wrap_i) begin
               pend_v <= 1'b0;
            end
         end
      end
   end

   assign run_o  = running;
   assign code_o = cur_code;

   // R7
   ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !wrap_i) |=> $stable(cur_code));

   // R10
   keep_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> running);

   // R2
   never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !code_nz && running) |=> (pend_code == $past(pend_code)));

endmodule

// File: rtl/mcd_phase_gen.sv
module mcd_phase_gen #(
   parameter int CODE_W   = 3,
   parameter int MIN_HALF = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              wrap_o,
   output logic              lvl_a_o,
   output logic              lvl_b_o,
   output logic              rise_o
);
   import mcd_pkg::*;

   localparam int P_MAX = period_half_max(CODE_W, MIN_HALF);
   localparam int CNT_W = $clog2(2 * P_MAX + 1);

   logic [CNT_W-1:0] pos_q;
   logic [CNT_W-1:0] plen;
   logic [CNT_W-1:0] pair_len;
   logic [CNT_W-1:0] hi_len;
   logic [CNT_W-1:0] h0, h1;
   logic [CNT_W-1:0] in0, in1;
   logic [CNT_W-1:0] pos_nx;

   always_comb begin
      plen     = CNT_W'(code_i) + CNT_W'(MIN_HALF - 1);
      pair_len = plen << 1;
      hi_len   = (plen + CNT_W'(1)) >> 1;
      h0       = pos_q;
      h1       = pos_q + CNT_W'(1);
      in0      = (h0 >= plen) ? (h0 - plen) : h0;
      in1      = (h1 >= plen) ? (h1 - plen) : h1;
      pos_nx   = pos_q + CNT_W'(2);
      wrap_o   = run_i && (pos_nx >= pair_len);
      lvl_a_o  = run_i && (in0 < hi_len);
      lvl_b_o  = run_i && (in1 < hi_len);
      rise_o   = run_i && ((in0 == '0) || (in1 == '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pos_q <= '0;
      else if (!run_i)  pos_q <= '0;
      else if (wrap_o)  pos_q <= '0;
      else              pos_q <= pos_nx;
   end

   // R8
   pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pos_q[0]) && (pos_q < pair_len));

   // R7
   pair_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> (pos_q == '0));

endmodule

// File: rtl/mcd_dual_edge.sv
module mcd_dual_edge #(
   parameter bit STROBE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_a_i,
   input  logic lvl_b_i,
   input  logic rise_i,
   output logic clk_o,
   output logic stb_o
);

   logic p_q;
   logic n_q;
   logic b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_q <= 1'b0;
         b_q <= 1'b0;
      end else begin
         p_q <= lvl_a_i ^ n_q;
         b_q <= lvl_b_i;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) n_q <= 1'b0;
      else        n_q <= b_q ^ p_q;
   end

   assign clk_o = p_q ^ n_q;

   generate
      if (STROBE_EN) begin : g_stb
         logic stb_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stb_q <= 1'b0;
            else        stb_q <= rise_i;
         end
         assign stb_o = stb_q;
      end else begin : g_nostb
         assign stb_o = 1'b0;
      end
   endgenerate

   // R8
   second_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (clk_o == $past(lvl_b_i)));

endmodule

// File: rtl/mcd_frac_clkdiv.sv
module mcd_frac_clkdiv #(
   parameter int CODE_W       = 3,
   parameter int MIN_HALF     = 4,
   parameter int DEFAULT_CODE = 3,
   parameter bit STROBE_EN    = 1'b1
) (
   input  logic              core_clk,
   input  logic              rst_n,
   input  logic              start_bit,
   input  logic [CODE_W-1:0] ratio_code,
   output logic              mem_clk,
   output logic              mem_clk_rise
);

   generate
      if (CODE_W < 1 || CODE_W > 6) begin : g_bad_w
         $error("CODE_W out of range");
      end
      if (MIN_HALF < 4) begin : g_bad_min
         $error("MIN_HALF must be at least 4");
      end
      if (DEFAULT_CODE < 1 || DEFAULT_CODE >= (1 << CODE_W)) begin : g_bad_def
         $error("DEFAULT_CODE must be a nonzero code");
      end
   endgenerate

   logic              running;
   logic              wrap;
   logic              lvl_a, lvl_b, rise;
   logic [CODE_W-1:0] cur_code;

   mcd_ratio_ctl #(.CODE_W(CODE_W), .DEFAULT_CODE(DEFAULT_CODE)) u_ctl (
      .clk(core_clk), .rst_n(rst_n), .start_i(start_bit), .code_i(ratio_code),
      .wrap_i(wrap), .run_o(running), .code_o(cur_code)
   );

   mcd_phase_gen #(.CODE_W(CODE_W), .MIN_HALF(MIN_HALF)) u_phase (
      .clk(core_clk), .rst_n(rst_n), .run_i(running), .code_i(cur_code),
      .wrap_o(wrap), .lvl_a_o(lvl_a), .lvl_b_o(lvl_b), .rise_o(rise)
   );

   mcd_dual_edge #(.STROBE_EN(STROBE_EN)) u_out (
      .clk(core_clk), .rst_n(rst_n), .lvl_a_i(lvl_a), .lvl_b_i(lvl_b),
      .rise_i(rise), .clk_o(mem_clk), .stb_o(mem_clk_rise)
   );

   // R6
   stopped_low_chk: assert property (@(posedge core_clk) disable iff (!rst_n)
      !running |=> !mem_clk);

   // R9
   strobe_running_chk: assert property (@(posedge core_clk) disable iff (!rst_n)
      mem_clk_rise |-> running);

endmodule

// File: tb/tb_mcd_frac_clkdiv.sv
module tb_mcd_frac_clkdiv;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       start;
   logic [2:0] code;
   logic       mem_clk;
   logic       mem_rise;

   int n_vec = 0;
   int n_bad = 0;

   // reference model state
   bit m_run, m_pv, m_stq;
   int m_cur, m_pend, m_q;
   bit ea, eb, es;

   always #10 clk = ~clk;

   mcd_frac_clkdiv dut (
      .core_clk(clk), .rst_n(rst_n), .start_bit(start), .ratio_code(code),
      .mem_clk(mem_clk), .mem_clk_rise(mem_rise)
   );

   function automatic int idx(input int h, input int p);
      return (h >= p) ? h - p : h;
   endfunction

   // R8: high for ceil(P/2) half-cycles from the start of each period
   function automatic bit level(input int h, input int p);
      return idx(h, p) < (p + 1) / 2;
   endfunction

   task automatic check(input string tag, input bit act, input bit exp, input string what);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_reset;
      m_run = 0; m_pv = 0; m_stq = 0; m_cur = 3; m_pend = 3; m_q = 0;
   endtask

   // Reference for one core rising edge, from R1..R10.
   task automatic model_edge;
      int  p;
      bit  arm, wr;
      p   = m_cur + 3;                 // R1: period = code+3 half-cycles
      arm = start && !m_stq;
      wr  = 0;
      if (m_run) begin
         ea = level(m_q, p);
         eb = level(m_q + 1, p);
         es = (idx(m_q, p) == 0) || (idx(m_q + 1, p) == 0);
         wr = (m_q + 2 >= 2 * p);
         m_q = wr ? 0 : m_q + 2;
         if (wr && m_pv) m_cur = m_pend;          // R7
         if (arm && code != 0) begin m_pend = int'(code); m_pv = 1; end
         else if (wr) m_pv = 0;
      end else begin
         ea = 0; eb = 0; es = 0;                  // R6
         if (arm) begin
            m_run = 1; m_q = 0;
            if (code != 0) m_cur = int'(code);    // R2, R3
         end
         m_pv = 0;
      end
      m_stq = start;
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_edge();
      #5;
      check(tag, mem_clk, ea, "mem_clk first half");
      check(tag, mem_rise, es, "mem_clk_rise (R9)");
      @(negedge clk);
      #5;
      check(tag, mem_clk, eb, "mem_clk second half");
   endtask

   task automatic run(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   task automatic arm_code(input string tag, input int c, input int n);
      start = 1'b0; code = 3'(c);
      step(tag);
      start = 1'b1;
      run(tag, n);
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; start = 1'b0; code = 3'd0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); #5;
      rst_n = 1'b1;
      // R6: reset state
      check("R6", mem_clk, 1'b0, "mem_clk after reset");
      check("R9", mem_rise, 1'b0, "strobe after reset");

      // R4, R6: code without arming leaves output low
      code = 3'd5;
      run("R4", 10);
      // R2, R3: first arming with 000 starts at default /3
      code = 3'd0; start = 1'b1;
      run("R3", 24);
      // R10: start back to 0 keeps clock running; R4 new code not applied
      start = 1'b0; code = 3'd1;
      run("R10", 12);
      start = 1'b1;
      run("R1", 16);
      // R5: held start, code change ignored
      code = 3'd7;
      run("R5", 20);
      // R1, R7, R8: every code in turn
      for (int c = 2; c <= 7; c++) arm_code("R1", c, 4 * (c + 3));
      arm_code("R8", 1, 20);
      // R2: arming with 000 while running keeps current ratio
      arm_code("R2", 0, 30);
      // R7: two armings inside one pair, later one wins
      start = 1'b0; code = 3'd7; step("R7");
      start = 1'b1; step("R7");
      start = 1'b0; code = 3'd2; step("R7");
      start = 1'b1; run("R7", 40);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 3) == 0) start = ~start;
         if ($urandom_range(0, 2) == 0) code = 3'($urandom_range(0, 7));
         step("R7");
      end

      // reset mid-run returns to stopped low
      rst_n = 1'b0; start = 1'b0;
      model_reset();
      #20;
      rst_n = 1'b1;
      run("R6", 8);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule